// File: doc/BRIEF.md
# Conditional Branch Resolver

This block settles a relative branch in one step. It takes the address of the branch instruction, its form, a condition selector, the four condition flags and the offset field, all presented together with a valid strobe. From these it works out two things. The first is whether the branch is taken. The second is the address of the next instruction to execute.

The two branch forms differ only in offset width and instruction length:

- **Short form:** two bytes long, with an 8-bit signed displacement.
- **Long form:** four bytes long, with a 16-bit displacement.

In both forms the displacement is added to the address just past the branch instruction. All arithmetic wraps modulo the address width.

Magnitude conditions come in two separate families:

- **Unsigned family:** tested through the carry flag.
- **Signed family:** tested through the negative and overflow flags.

Because of this split, a compare of 0xFF against 0x00 reads as "higher" in the unsigned family and as "less" in the signed family.

Both results are held in registers. They change only on the clock edge where the strobe is high, and otherwise keep their last values.

Top module: `brcond_unit`

## Requirements
- R1: While `rst_n` is low, `next_pc_o` reads 0 and `taken_o` reads 0.
- R2: Both outputs update on the first rising clock edge at which `valid_i` is high. On edges where `valid_i` is low, both outputs keep their previous values regardless of the other inputs.
- R3: A taken short branch (`long_i`=0) produces `pc_i` + 2 + the sign extension of `offset_i[7:0]`, modulo 2^16. Bits `offset_i[15:8]` have no effect in the short form. For example, 0x35 adds 0x37 in total, and 0xC7 subtracts 0x37.
- R4: A taken long branch (`long_i`=1) produces `pc_i` + 4 + `offset_i`, modulo 2^16.
- R5: A branch that is not taken produces `pc_i`+2 in the short form and `pc_i`+4 in the long form.
- R6: Selector `cond_i`=0 (always) is taken and selector 7 (never) is not taken, whatever the flags are.
- R7: Selector 1 (equal) is taken when Z=1. Selector 2 (not equal) is taken when Z=0.
- R8: Selector 3 (unsigned higher) is taken when (C|Z)=0. Selector 4 (unsigned lower-or-same) is taken when (C|Z)=1.
- R9: Selector 5 (signed greater) is taken when (Z|(N^V))=0. Selector 6 (signed less-or-equal) is taken when (Z|(N^V))=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Strobe: evaluate the presented branch |
| pc_i | input | 16 | Address of the branch instruction |
| long_i | input | 1 | 0 selects the short form, 1 selects the long form |
| cond_i | input | 3 | Condition selector (encoding in R6 to R9) |
| flag_n_i | input | 1 | Negative flag |
| flag_z_i | input | 1 | Zero flag |
| flag_v_i | input | 1 | Overflow flag |
| flag_c_i | input | 1 | Carry flag |
| offset_i | input | 16 | Displacement; only bits 7:0 are used in the short form |
| next_pc_o | output | 16 | Registered next instruction address |
| taken_o | output | 1 | Registered branch-taken indication |

## Verification
Two situations are the hardest to provoke:

- **Address wrap.** Reaching it needs a branch near the top or bottom of the address space together with a displacement that pushes the sum past the boundary.
- **Flag disagreement.** Here the signed and unsigned families must give opposite answers for the same flags, such as N=1 with C=0.

The stimulus handles both in two ways. Directed cases place the address at 0xFFFE and 0x0001 and apply the flag pattern left by a 0xFF-minus-0x00 compare. The random phase draws the address, flags, selector and offset without constraint, so wrapping sums and mixed flag patterns occur often.

// File: rtl/brcond_pkg.sv
package brcond_pkg;
   typedef enum logic [2:0] {
      COND_ALWAYS = 3'd0,
      COND_EQ     = 3'd1,
      COND_NE     = 3'd2,
      COND_HI     = 3'd3,
      COND_LS     = 3'd4,
      COND_GT     = 3'd5,
      COND_LE     = 3'd6,
      COND_NEVER  = 3'd7
   } cond_e;

   typedef struct packed {
      logic n;
      logic z;
      logic v;
      logic c;
   } flags_t;
endpackage

// File: rtl/brcond_eval.sv
module brcond_eval
   import brcond_pkg::*;
(
   input  logic [2:0] cond_i,
   input  flags_t     flags_i,
   output logic       taken_o
);
   logic ugt;
   logic sgt;

   assign ugt = ~(flags_i.c | flags_i.z);
   assign sgt = ~(flags_i.z | (flags_i.n ^ flags_i.v));

   always_comb begin
      unique case (cond_e'(cond_i))
         COND_ALWAYS: taken_o = 1'b1;
         COND_EQ:     taken_o = flags_i.z;
         COND_NE:     taken_o = ~flags_i.z;
         COND_HI:     taken_o = ugt;
         COND_LS:     taken_o = ~ugt;
         COND_GT:     taken_o = sgt;
         COND_LE:     taken_o = ~sgt;
         default:     taken_o = 1'b0;
      endcase
   end
endmodule

// File: rtl/brcond_target.sv
module brcond_target #(
   parameter int ADDR_W      = 16,
   parameter int SHORT_OFF_W = 8,
   parameter int LONG_OFF_W  = 16,
   parameter int SHORT_LEN   = 2,
   parameter int LONG_LEN    = 4,
   parameter bit ONE_ADDER   = 1'b1
) (
   input  logic [ADDR_W-1:0]     pc_i,
   input  logic                  long_i,
   input  logic                  taken_i,
   input  logic [LONG_OFF_W-1:0] offset_i,
   output logic [ADDR_W-1:0]     next_pc_o
);
   localparam logic [ADDR_W-1:0] SLEN = ADDR_W'(SHORT_LEN);
   localparam logic [ADDR_W-1:0] LLEN = ADDR_W'(LONG_LEN);

   logic [ADDR_W-1:0] short_disp;
   logic [ADDR_W-1:0] long_disp;
   logic [ADDR_W-1:0] fall_pc;

   assign short_disp = ADDR_W'($signed(offset_i[SHORT_OFF_W-1:0]));
   assign long_disp  = ADDR_W'(offset_i);
   assign fall_pc    = pc_i + (long_i ? LLEN : SLEN);

   generate
      if (ONE_ADDER) begin : g_shared
         logic [ADDR_W-1:0] disp;
         assign disp      = !taken_i ? '0 : (long_i ? long_disp : short_disp);
         assign next_pc_o = fall_pc + disp;
      end else begin : g_parallel
         logic [ADDR_W-1:0] short_tgt;
         logic [ADDR_W-1:0] long_tgt;
         assign short_tgt = pc_i + SLEN + short_disp;
         assign long_tgt  = pc_i + LLEN + long_disp;
         assign next_pc_o = !taken_i ? fall_pc : (long_i ? long_tgt : short_tgt);
      end
   endgenerate
endmodule

// File: rtl/brcond_unit.sv
module brcond_unit
   import brcond_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int SHORT_OFF_W = 8,
   parameter int LONG_OFF_W  = 16,
   parameter int SHORT_LEN   = 2,
   parameter int LONG_LEN    = 4,
   parameter bit ONE_ADDER   = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  valid_i,
   input  logic [ADDR_W-1:0]     pc_i,
   input  logic                  long_i,
   input  logic [2:0]            cond_i,
   input  logic                  flag_n_i,
   input  logic                  flag_z_i,
   input  logic                  flag_v_i,
   input  logic                  flag_c_i,
   input  logic [LONG_OFF_W-1:0] offset_i,
   output logic [ADDR_W-1:0]     next_pc_o,
   output logic                  taken_o
);
   generate
      if (SHORT_OFF_W > LONG_OFF_W) begin : g_bad_off
         $error("short offset wider than long offset");
      end
      if (LONG_OFF_W > ADDR_W) begin : g_bad_addr
         $error("long offset wider than address");
      end
      if (SHORT_LEN >= LONG_LEN) begin : g_bad_len
         $error("short form must be shorter than long form");
      end
   endgenerate

   flags_t            flags;
   logic              taken_d;
   logic [ADDR_W-1:0] next_pc_d;

   assign flags = '{n: flag_n_i, z: flag_z_i, v: flag_v_i, c: flag_c_i};

   brcond_eval u_eval (
      .cond_i  (cond_i),
      .flags_i (flags),
      .taken_o (taken_d)
   );

   brcond_target #(
      .ADDR_W      (ADDR_W),
      .SHORT_OFF_W (SHORT_OFF_W),
      .LONG_OFF_W  (LONG_OFF_W),
      .SHORT_LEN   (SHORT_LEN),
      .LONG_LEN    (LONG_LEN),
      .ONE_ADDER   (ONE_ADDER)
   ) u_target (
      .pc_i      (pc_i),
      .long_i    (long_i),
      .taken_i   (taken_d),
      .offset_i  (offset_i),
      .next_pc_o (next_pc_d)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         next_pc_o <= '0;
         taken_o   <= 1'b0;
      end else if (valid_i) begin
         next_pc_o <= next_pc_d;
         taken_o   <= taken_d;
      end
   end
endmodule

// File: rtl/brcond_checker.sv
module brcond_checker #(
   parameter int ADDR_W     = 16,
   parameter int LONG_OFF_W = 16,
   parameter int SHORT_LEN  = 2,
   parameter int LONG_LEN   = 4
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  valid_i,
   input logic [ADDR_W-1:0]     pc_i,
   input logic                  long_i,
   input logic [2:0]            cond_i,
   input logic                  flag_z_i,
   input logic [LONG_OFF_W-1:0] offset_i,
   input logic [ADDR_W-1:0]     next_pc_o,
   input logic                  taken_o
);
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_i |=> ($stable(next_pc_o) && $stable(taken_o))); // R2
   AST_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && cond_i == 3'd0) |=> taken_o); // R6
   AST_NEVER_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && cond_i == 3'd7) |=> !taken_o); // R6
   AST_EQ_FOLLOWS_Z: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && cond_i == 3'd1) |=> (taken_o == $past(flag_z_i))); // R7
   AST_SHORT_FALLTHRU: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && !long_i) |=> (taken_o || next_pc_o == $past(pc_i) + ADDR_W'(SHORT_LEN))); // R5
   AST_LONG_FALLTHRU: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && long_i) |=> (taken_o || next_pc_o == $past(pc_i) + ADDR_W'(LONG_LEN))); // R5
   AST_LONG_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && long_i) |=> (!taken_o ||
         next_pc_o == $past(pc_i) + ADDR_W'(LONG_LEN) + ADDR_W'($past(offset_i)))); // R4
endmodule

bind brcond_unit brcond_checker #(
   .ADDR_W     (ADDR_W),
   .LONG_OFF_W (LONG_OFF_W),
   .SHORT_LEN  (SHORT_LEN),
   .LONG_LEN   (LONG_LEN)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .valid_i   (valid_i),
   .pc_i      (pc_i),
   .long_i    (long_i),
   .cond_i    (cond_i),
   .flag_z_i  (flag_z_i),
   .offset_i  (offset_i),
   .next_pc_o (next_pc_o),
   .taken_o   (taken_o)
);

// File: tb/brcond_unit_bench.sv
module brcond_unit_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        valid_i = 1'b0;
   logic [15:0] pc_i = '0;
   logic        long_i = 1'b0;
   logic [2:0]  cond_i = '0;
   logic        flag_n_i = 1'b0, flag_z_i = 1'b0, flag_v_i = 1'b0, flag_c_i = 1'b0;
   logic [15:0] offset_i = '0;
   logic [15:0] next_pc_o;
   logic        taken_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   brcond_unit u_brcond_unit (
      .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .pc_i(pc_i), .long_i(long_i),
      .cond_i(cond_i), .flag_n_i(flag_n_i), .flag_z_i(flag_z_i), .flag_v_i(flag_v_i),
      .flag_c_i(flag_c_i), .offset_i(offset_i), .next_pc_o(next_pc_o), .taken_o(taken_o)
   );

   function automatic bit exp_taken(input logic [2:0] c, input bit n, z, v, cy);
      case (c)
         3'd0: return 1'b1;
         3'd1: return z;
         3'd2: return !z;
         3'd3: return !(cy || z);
         3'd4: return (cy || z);
         3'd5: return !(z || (n != v));
         3'd6: return (z || (n != v));
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic [15:0] exp_pc(input logic [15:0] pc, input bit lng, tk,
                                          input logic [15:0] off);
      logic [15:0] base;
      base = pc + (lng ? 16'd4 : 16'd2);
      if (!tk) return base;
      if (lng) return base + off;
      return base + {{8{off[7]}}, off[7:0]};
   endfunction

   task automatic check(input string req, input logic [15:0] act_pc, exp_pcv,
                        input bit act_tk, exp_tk);
      checks++;
      if (act_pc !== exp_pcv || act_tk !== exp_tk) begin
         errors++;
         $display("FAIL %s: next_pc=%h taken=%0b expected next_pc=%h taken=%0b",
                  req, act_pc, act_tk, exp_pcv, exp_tk);
      end
   endtask

   task automatic run(input string req, input logic [15:0] pc, input bit lng,
                      input logic [2:0] c, input bit n, z, v, cy, input logic [15:0] off);
      bit tk;
      @(negedge clk);
      pc_i = pc; long_i = lng; cond_i = c; offset_i = off;
      flag_n_i = n; flag_z_i = z; flag_v_i = v; flag_c_i = cy;
      valid_i = 1'b1;
      @(negedge clk);
      valid_i = 1'b0;
      tk = exp_taken(c, n, z, v, cy);
      check(req, next_pc_o, exp_pc(pc, lng, tk, off), taken_o, tk);
   endtask

   initial begin
      #400000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [15:0] hold_pc;
      bit hold_tk;
      void'($urandom(32'd2014));
      repeat (3) @(negedge clk);
      check("R1 reset", next_pc_o, 16'h0000, taken_o, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;

      // R3: short form, positive and negative displacement, upper bits ignored
      run("R3 short +0x35", 16'h2000, 0, 3'd0, 0, 0, 0, 0, 16'h0035);
      check("R3 value", next_pc_o, 16'h2037, taken_o, 1'b1);
      run("R3 short 0xC7", 16'h2000, 0, 3'd0, 0, 0, 0, 0, 16'h00C7);
      check("R3 value", next_pc_o, 16'h1FC9, taken_o, 1'b1);
      run("R3 upper offset bits ignored", 16'h2000, 0, 3'd0, 0, 0, 0, 0, 16'hA535);
      check("R3 value", next_pc_o, 16'h2037, taken_o, 1'b1);
      run("R3 wrap low", 16'h0001, 0, 3'd0, 0, 0, 0, 0, 16'h0080);
      // R4: long form, taken/not by Z, and wrap
      run("R4 long eq taken", 16'h2000, 1, 3'd1, 0, 1, 0, 0, 16'h021A);
      check("R4 value", next_pc_o, 16'h221E, taken_o, 1'b1);
      run("R5 long eq not taken", 16'h2000, 1, 3'd1, 0, 0, 0, 0, 16'h021A);
      check("R5 value", next_pc_o, 16'h2004, taken_o, 1'b0);
      run("R4 long wrap", 16'hFFFE, 1, 3'd0, 0, 0, 0, 0, 16'h0010);
      run("R5 short fallthrough wrap", 16'hFFFE, 0, 3'd7, 1, 1, 1, 1, 16'h0010);
      // R8/R9: flags of a 0xFF - 0x00 compare: N=1 Z=0 V=0 C=0
      run("R8 unsigned higher 0xFF>0x00", 16'h3000, 0, 3'd3, 1, 0, 0, 0, 16'h0010);
      run("R9 signed greater -1<0", 16'h3000, 0, 3'd5, 1, 0, 0, 0, 16'h0010);
      run("R9 signed le -1<0", 16'h3000, 0, 3'd6, 1, 0, 0, 0, 16'h0010);
      run("R9 gt with N=V=1", 16'h3000, 0, 3'd5, 1, 0, 1, 0, 16'h0010);
      run("R8 lower-same via C", 16'h3000, 1, 3'd4, 0, 0, 0, 1, 16'h0100);
      run("R7 ne with Z=0", 16'h4000, 0, 3'd2, 0, 0, 0, 0, 16'h00FE);
      run("R6 always with all flags set", 16'h4000, 0, 3'd0, 1, 1, 1, 1, 16'h0004);
      run("R6 never with no flags", 16'h4000, 1, 3'd7, 0, 0, 0, 0, 16'h0004);

      // R2: inputs change without strobe, outputs hold
      hold_pc = next_pc_o; hold_tk = taken_o;
      @(negedge clk);
      pc_i = 16'h1234; cond_i = 3'd0; long_i = 1'b1; offset_i = 16'h5555;
      repeat (2) @(negedge clk);
      check("R2 hold without strobe", next_pc_o, hold_pc, taken_o, hold_tk);

      for (int i = 0; i < 400; i++) begin
         logic [15:0] rpc, roff;
         logic [3:0]  rf;
         logic [2:0]  rc;
         bit          rl;
         string       tag;
         rpc = 16'($urandom); roff = 16'($urandom);
         rf = 4'($urandom); rc = 3'($urandom); rl = 1'($urandom);
         case (rc)
            3'd0, 3'd7: tag = "R6 random";
            3'd1, 3'd2: tag = "R7 random";
            3'd3, 3'd4: tag = "R8 random";
            default:    tag = "R9 random";
         endcase
         if (i % 5 == 0) tag = rl ? "R4 random" : "R3 random";
         run(tag, rpc, rl, rc, rf[3], rf[2], rf[1], rf[0], roff);
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule